// File: doc/BRIEF.md
# Iterative Shift Integer ALU

This unit is the integer execution stage of a small 32-bit RISC core. It computes bitwise AND, OR and XOR, two's-complement addition and subtraction, and three kinds of shift (left logical, right logical and right arithmetic). A caller raises `en` with the operands and an operation code. The unit raises `valid` once the `result` word is ready. Logic and arithmetic operations finish in a single cycle. Shifts move the operand by one bit position per clock, so the unit needs no full barrel shifter.

The unit captures the operands and the operation code on the cycle it accepts a request. Changes on those inputs while the request is in progress have no effect on the answer. The result and `valid` stay in place for as long as `en` stays high. When `en` is dropped, the unit returns to idle on the next clock edge and waits for the next request.

Top module: `alu_iter_top`

## Requirements
- R1: `opSel` selects the operation with this encoding: 0 AND, 1 OR, 2 XOR, 3 ADD, 4 SUB, 5 shift left logical, 6 shift right logical, 7 shift right arithmetic. Codes 0 to 2 return the bitwise function of `opA` and `opB`.
- R2: ADD returns `opA + opB` and SUB returns `opA - opB`, both as two's-complement sums truncated to 32 bits, with no overflow indication.
- R3: A shift uses only bits 4:0 of `opB` as its amount. Bits 31:5 have no effect on either the result or the latency.
- R4: A left shift fills the low end with zeros. A logical right shift fills the high end with zeros. An arithmetic right shift fills the high end with copies of bit 31 of `opA`. Each result equals a direct full-width shift by the same amount.
- R5: For codes 0 to 4, and for any shift whose amount is zero, `valid` is high one clock after the edge that samples `en` in idle. A zero-amount shift returns `opA` unchanged.
- R6: A shift by an amount n between 1 and 31 raises `valid` exactly n+1 clocks after the edge that samples `en` in idle. `valid` stays low in between.
- R7: While `valid` is high and `en` stays high, `valid` and `result` hold their values.
- R8: When `en` is low on an edge at which `valid` is high, `valid` is low after that edge. The next request is taken on a later edge at which `en` is high. `valid` never rises without `en`.
- R9: `opA`, `opB` and `opSel` are sampled only on the accepting edge. Changing them during a shift, or while `valid` is held, does not alter `result`.
- R10: After reset, `valid` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Request; held high until valid, dropped to release |
| opA | input | 32 | First operand; the value shifted by shift operations |
| opB | input | 32 | Second operand; bits 4:0 give the shift amount |
| opSel | input | 3 | Operation code (see R1) |
| result | output | 32 | Computed word, meaningful while valid is high |
| valid | output | 1 | Result ready for the current request |

## Verification
The bench targets the shift corners, where each kind of error shows up in a distinct way.
- Amounts of 31 with a negative `opA` would expose zero fill in place of sign fill.
- An `opB` of 32 or 35 would give the wrong latency and result if the upper bits leaked into the shift count.
- An amount of zero would hang the unit, or take a wrong extra cycle, if zero were not taken as a fast case.
- Carries out of bit 31 on ADD and SUB would show up if the sum were not truncated.

The bench also checks handshake timing. It counts clocks to `valid` for every request, so an off-by-one in the shift counter is reported. It also disturbs the operands in the middle of a shift, which reports a design that reads its inputs live.

// File: rtl/alu_iter_pkg.sv
package alu_iter_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4,
    OP_SLL = 3'd5,
    OP_SRL = 3'd6,
    OP_SRA = 3'd7
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands, op code and shift count
    logic quick;   // write the single-cycle result
    logic step;    // advance the shifter by one bit
    logic finish;  // write the shifter output as the result
  } aluStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } aluState_e;

  function automatic logic isShiftOp(aluOp_e op);
    return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  endfunction

endpackage

// File: rtl/alu_iter_ctrl.sv
module alu_iter_ctrl
  import alu_iter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       fastStart,
  input  logic       lastStep,
  output aluStrobe_t strobe,
  output logic       valid,
  output logic       idle,
  output logic       shifting
);

  aluState_e stateQ;
  aluState_e stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (en) begin
          strobe.load = 1'b1;
          if (fastStart) begin
            strobe.quick = 1'b1;
            stateD       = ST_DONE;
          end else begin
            stateD = ST_SHIFT;
          end
        end
      end
      ST_SHIFT: begin
        strobe.step = 1'b1;
        if (lastStep) begin
          strobe.finish = 1'b1;
          stateD        = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!en) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign valid    = (stateQ == ST_DONE);
  assign idle     = (stateQ == ST_IDLE);
  assign shifting = (stateQ == ST_SHIFT);

endmodule

// File: rtl/alu_iter_datapath.sv
module alu_iter_datapath
  import alu_iter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opSel,
  input  aluStrobe_t        strobe,
  output logic              fastStart,
  output logic              lastStep,
  output logic [DATA_W-1:0] result
);

  localparam int SHAMT_W = $clog2(DATA_W);

  aluOp_e              opIn;
  aluOp_e              opQ;
  logic [SHAMT_W-1:0]  amtIn;
  logic [SHAMT_W-1:0]  cntQ;
  logic [DATA_W-1:0]   workQ;
  logic [DATA_W-1:0]   resultQ;
  logic [DATA_W-1:0]   quickVal;
  logic [DATA_W-1:0]   stepVal;
  logic                leftDir;
  logic                fillBit;

  assign opIn      = aluOp_e'(opSel);
  assign amtIn     = opB[SHAMT_W-1:0];
  assign fastStart = !isShiftOp(opIn) || (amtIn == '0);
  assign lastStep  = (cntQ == SHAMT_W'(1));

  always_comb begin
    unique case (opIn)
      OP_AND:  quickVal = opA & opB;
      OP_OR:   quickVal = opA | opB;
      OP_XOR:  quickVal = opA ^ opB;
      OP_ADD:  quickVal = opA + opB;
      OP_SUB:  quickVal = opA - opB;
      default: quickVal = opA;  // shift by zero
    endcase
  end

  assign leftDir = (opQ == OP_SLL);
  assign fillBit = (opQ == OP_SRA) ? workQ[DATA_W-1] : 1'b0;

  // One-position shifter, built bit by bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fromLow;
    logic fromHigh;
    if (i == 0) begin : g_lo
      assign fromLow = 1'b0;
    end else begin : g_lo
      assign fromLow = workQ[i-1];
    end
    if (i == DATA_W - 1) begin : g_hi
      assign fromHigh = fillBit;
    end else begin : g_hi
      assign fromHigh = workQ[i+1];
    end
    assign stepVal[i] = leftDir ? fromLow : fromHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workQ   <= '0;
      cntQ    <= '0;
      opQ     <= OP_AND;
      resultQ <= '0;
    end else begin
      if (strobe.load) begin
        workQ <= opA;
        cntQ  <= amtIn;
        opQ   <= opIn;
      end
      if (strobe.quick) resultQ <= quickVal;
      if (strobe.step) begin
        workQ <= stepVal;
        cntQ  <= cntQ - SHAMT_W'(1);
      end
      if (strobe.finish) resultQ <= stepVal;
    end
  end

  assign result = resultQ;

endmodule

// File: rtl/alu_iter_top.sv
module alu_iter_top
  import alu_iter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opSel,
  output logic [DATA_W-1:0] result,
  output logic              valid
);

  aluStrobe_t strobe;
  logic       fastStart;
  logic       lastStep;
  logic       idle;
  logic       shifting;

  alu_iter_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .en       (en),
    .fastStart(fastStart),
    .lastStep (lastStep),
    .strobe   (strobe),
    .valid    (valid),
    .idle     (idle),
    .shifting (shifting)
  );

  alu_iter_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .strobe   (strobe),
    .fastStart(fastStart),
    .lastStep (lastStep),
    .result   (result)
  );

endmodule

// File: rtl/alu_iter_checker.sv
module alu_iter_checker #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               en,
  input logic [2:0]         opSel,
  input logic [SHAMT_W-1:0] shAmt,
  input logic               valid,
  input logic [DATA_W-1:0]  result,
  input logic               idle,
  input logic               shifting
);

  logic quickReq;
  logic shiftReq;
  assign quickReq = idle && en && ((opSel < 3'd5) || (shAmt == '0));
  assign shiftReq = idle && en && (opSel >= 3'd5) && (shAmt != '0);

  AST_QUICK_DONE: assert property (@(posedge clk) disable iff (!rstN)
    quickReq |=> valid);  // R5

  AST_SHIFT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    shiftReq |=> (!valid && shifting));  // R6

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (valid && en) |=> (valid && $stable(result)));  // R7

  AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !en) |=> (!valid && idle));  // R8

  AST_NO_UNASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !valid) |=> !valid);  // R8

endmodule

bind alu_iter_top alu_iter_checker #(.DATA_W(DATA_W), .SHAMT_W(5)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .en      (en),
  .opSel   (opSel),
  .shAmt   (opB[4:0]),
  .valid   (valid),
  .result  (result),
  .idle    (idle),
  .shifting(shifting)
);

// File: tb/test_alu_iter_top.sv
module test_alu_iter_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [31:0] result;
  logic        valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  alu_iter_top i_alu_iter_top (
    .clk(clk), .rstN(rstN), .en(en), .opA(opA), .opB(opB),
    .opSel(opSel), .result(result), .valid(valid)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expVal(input logic [2:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    logic [4:0] sa;
    sa = b[4:0];
    case (op)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return a + b;
      3'd4: return a - b;
      3'd5: return a << sa;
      3'd6: return a >> sa;
      default: return $unsigned($signed(a) >>> sa);
    endcase
  endfunction

  function automatic int expLat(input logic [2:0] op, input logic [31:0] b);
    if (op >= 3'd5 && b[4:0] != 5'd0) return int'(b[4:0]) + 1;
    return 1;
  endfunction

  // Issue one request; optionally disturb inputs after acceptance (R9)
  task automatic runOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input string req, input int holdExtra, input bit disturb);
    int lat;
    logic [31:0] e;
    logic [31:0] held;
    e = expVal(op, a, b);
    @(negedge clk);
    opSel = op; opA = a; opB = b; en = 1'b1;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (disturb && lat == 1) begin
        opA = ~a; opB = b ^ 32'h0000_0013; opSel = op ^ 3'd2;
      end
      if (valid || lat > 40) break;
    end
    check(lat == expLat(op, b), "R6 latency", 32'(lat), 32'(expLat(op, b)));
    check(result === e, req, result, e);
    held = result;
    for (int k = 0; k < holdExtra; k++) begin
      @(negedge clk);
      if (disturb) begin opA = $urandom; opB = $urandom; end
      check(valid && result === held, "R7 hold", result, held);
    end
    en = 1'b0;
    @(negedge clk);
    check(!valid, "R8 release", 32'(valid), 32'd0);
  endtask

  initial begin
    logic [2:0] rop;
    logic [31:0] ra;
    logic [31:0] rb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!valid, "R10 valid reset", 32'(valid), 32'd0);
    check(result === 32'd0, "R10 result reset", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R8: en low, nothing happens
    repeat (3) @(negedge clk);
    check(!valid, "R8 no unasked valid", 32'(valid), 32'd0);

    runOp(3'd0, 32'hF0F0_1234, 32'h0FF0_FF00, "R1 AND", 0, 0);
    runOp(3'd1, 32'hF0F0_1234, 32'h0FF0_FF00, "R1 OR", 0, 0);
    runOp(3'd2, 32'hF0F0_1234, 32'h0FF0_FF00, "R1 XOR", 0, 0);
    runOp(3'd3, 32'hFFFF_FFFF, 32'h0000_0001, "R2 ADD wrap", 0, 0);
    runOp(3'd4, 32'h0000_0000, 32'h0000_0001, "R2 SUB wrap", 0, 0);
    runOp(3'd3, 32'h7FFF_FFFF, 32'h0000_0001, "R2 ADD signed overflow", 0, 0);
    runOp(3'd5, 32'h0000_0001, 32'd31, "R4 SLL 31", 0, 0);
    runOp(3'd6, 32'h8000_0000, 32'd31, "R4 SRL 31", 0, 0);
    runOp(3'd7, 32'h8000_0000, 32'd31, "R4 SRA 31 sign fill", 0, 0);
    runOp(3'd7, 32'h4000_0000, 32'd5, "R4 SRA positive", 0, 0);
    runOp(3'd5, 32'hDEAD_BEEF, 32'd0, "R5 SLL zero amount", 0, 0);
    runOp(3'd7, 32'hDEAD_BEEF, 32'd32, "R3 SRA amount 32 is zero", 0, 0);
    runOp(3'd6, 32'hDEAD_BEEF, 32'hFFFF_FFE3, "R3 SRL upper bits ignored", 0, 0);
    runOp(3'd0, 32'h1234_5678, 32'hFFFF_0000, "R5 quick op", 2, 0);
    runOp(3'd6, 32'hCAFE_F00D, 32'd9, "R7 held after shift", 4, 0);
    runOp(3'd7, 32'h8765_4321, 32'd12, "R9 disturbed shift", 2, 1);
    runOp(3'd3, 32'h0000_0010, 32'h0000_0020, "R9 disturbed quick", 2, 1);
    runOp(3'd5, 32'h0000_00FF, 32'd1, "R6 SLL by one", 0, 0);

    for (int n = 0; n < 150; n++) begin
      rop = 3'($urandom);
      ra  = $urandom;
      rb  = $urandom;
      runOp(rop, ra, rb, (rop >= 3'd5) ? "R4 random shift" : "R1 R2 random op", n % 3, n % 5 == 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule